// File: doc/BRIEF.md
# PHY Management Register File

This block holds the management registers of a simple 10/100 Ethernet PHY. It is meant to sit behind the command logic of a MAC's management port. That logic presents a register index and either a write strobe with data or a read strobe. The block answers reads one clock later. There are sixteen 16-bit registers: a control word, a status word, two identity words, an advertisement word, a link-partner ability word and ten general words.

A level input reports whether the link is up. The block folds that level into the status word and the partner-ability word. This happens on the clock after the level changes, and again whenever the registers are re-initialised. The re-initialisation happens on the hardware reset input, or when software writes the control word with its top bit set. The identity and status words are read-only. Indices at or above sixteen have no register behind them.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After the reset input is held high, index 0 reads 0x1000, index 1 reads 0x7848 with bit 2 equal to the link level, index 2 reads 0x2000, index 3 reads 0x5C90, index 4 reads 0x01E1, index 5 reads 0x01E1 with the link up and 0x0000 with it down, and indices 6 to 15 read 0. The read data output is 0 after reset.
- R2: One clock after the link input rises, status bit 2 is 1 and the bits of 0x01E1 are set in the partner-ability word (index 5), with no access needed.
- R3: One clock after the link input falls, status bit 2 is 0 and the partner-ability word keeps only the bits of 0x01FF.
- R4: A control write (index 0) with bit 15 clear stores the data. A control write with bit 15 set re-initialises every register and stores nothing.
- R5: Writes to index 1, 2 and 3 change nothing.
- R6: Writes to index 4 to 15 store the data. A value written to index 5 persists until the next link change or re-initialisation.
- R7: A write to an index of 16 or more changes no register. A read of such an index returns 0.
- R8: Read data is registered. It shows the word held before the clock edge on which the read strobe is sampled, and it holds its value while no read is strobed. A write in the same cycle is not visible in that read.
- R9: The re-initialisation caused by a control write applies the present link level to index 1 and index 5, exactly as R1 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_i | input | ADDR_W (5) | Register index for the current access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| link_up_i | input | 1 | Link level, 1 = up |
| rd_data_o | output | 16 | Registered read data |

## Verification
Every register effect is due on the clock edge that samples the stimulus. This covers a stored write, a re-initialisation and a link change. Read data appears on the same edge and so is visible one cycle after the strobe. The bench drives all inputs on the falling edge, applies them to its model on the rising edge, and compares the read output with the model on the next falling edge. Each requirement check therefore samples exactly one cycle after its read strobe. The hold cases wait extra idle cycles before sampling again.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int PHY_REGS = 16;
    localparam int PHY_DW   = 16;
    localparam int IDX_BITS = $clog2(PHY_REGS);

    typedef logic [PHY_DW-1:0] word_t;

    // Indices whose behaviour is fixed by function
    localparam int IDX_CTRL    = 0;
    localparam int IDX_STAT    = 1;
    localparam int IDX_ID_HI   = 2;
    localparam int IDX_ID_LO   = 3;
    localparam int IDX_ADV     = 4;
    localparam int IDX_PARTNER = 5;

    localparam word_t INIT_CTRL    = 16'h1000;
    localparam word_t INIT_STAT    = 16'h7848;
    localparam word_t INIT_ID_HI   = 16'h2000;
    localparam word_t INIT_ID_LO   = 16'h5C90;
    localparam word_t INIT_ADV     = 16'h01E1;

    localparam int    SOFT_RST_BIT    = 15;
    localparam int    LINK_BIT        = 2;
    localparam word_t PARTNER_UP_SET  = 16'h01E1;
    localparam word_t PARTNER_DN_KEEP = 16'h01FF;

    typedef enum logic [1:0] {
        WR_NONE     = 2'd0,
        WR_STORE    = 2'd1,
        WR_SOFT_RST = 2'd2
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e             kind;
        logic [IDX_BITS-1:0]  idx;
        word_t                data;
    } wr_cmd_t;

    function automatic word_t init_word(int i);
        case (i)
            IDX_CTRL:  return INIT_CTRL;
            IDX_STAT:  return INIT_STAT;
            IDX_ID_HI: return INIT_ID_HI;
            IDX_ID_LO: return INIT_ID_LO;
            IDX_ADV:   return INIT_ADV;
            default:   return '0;
        endcase
    endfunction

    function automatic logic write_locked(int i);
        return (i == IDX_STAT) || (i == IDX_ID_HI) || (i == IDX_ID_LO);
    endfunction

    // Fold the link level into one word; words other than status and
    // partner ability pass through unchanged.
    function automatic word_t link_word(int i, word_t w, logic up);
        word_t r;
        r = w;
        if (i == IDX_STAT) begin
            r[LINK_BIT] = up;
        end else if (i == IDX_PARTNER) begin
            r = up ? (w | PARTNER_UP_SET) : (w & PARTNER_DN_KEEP);
        end
        return r;
    endfunction

endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]   idx_i,
    input  logic                wr_en_i,
    input  word_t               wr_data_i,
    output logic                hit_o,
    output logic [IDX_BITS-1:0] idx_o,
    output wr_cmd_t             cmd_o
);

    logic in_range;
    logic locked;
    logic soft_rst;

    assign in_range = int'(idx_i) < PHY_REGS;
    assign idx_o    = idx_i[IDX_BITS-1:0];
    assign hit_o    = in_range;
    assign locked   = write_locked(int'(idx_o));
    assign soft_rst = (int'(idx_o) == IDX_CTRL) && wr_data_i[SOFT_RST_BIT];

    always_comb begin
        cmd_o.idx  = idx_o;
        cmd_o.data = wr_data_i;
        if (!wr_en_i || !in_range || locked) begin
            cmd_o.kind = WR_NONE;
        end else if (soft_rst) begin
            cmd_o.kind = WR_SOFT_RST;
        end else begin
            cmd_o.kind = WR_STORE;
        end
    end

endmodule

// File: rtl/phy_mgmt_store.sv
module phy_mgmt_store
    import phy_mgmt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd_i,
    input  logic    link_up_i,
    output word_t   regs_o [PHY_REGS]
);

    word_t regs_q [PHY_REGS];
    word_t nxt    [PHY_REGS];
    logic  link_q;
    logic  reinit;
    logic  link_chg;

    assign reinit   = rst || (cmd_i.kind == WR_SOFT_RST);
    assign link_chg = link_up_i != link_q;

    for (genvar g = 0; g < PHY_REGS; g++) begin : g_word
        logic  wr_hit;
        word_t base;
        assign wr_hit = (cmd_i.kind == WR_STORE) && (cmd_i.idx == IDX_BITS'(g));
        assign base   = reinit ? init_word(g)
                               : (wr_hit ? cmd_i.data : regs_q[g]);
        assign nxt[g] = (reinit || link_chg) ? link_word(g, base, link_up_i) : base;
        assign regs_o[g] = regs_q[g];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PHY_REGS; i++) begin
            regs_q[i] <= nxt[i];
        end
        link_q <= link_up_i;
    end

    assert_link_up_R2: assert property (@(posedge clk) disable iff (rst)
        link_up_i |=> regs_q[IDX_STAT][LINK_BIT]);

    assert_partner_up_R2: assert property (@(posedge clk) disable iff (rst)
        (!link_q && link_up_i) |=> ((regs_q[IDX_PARTNER] & PARTNER_UP_SET) == PARTNER_UP_SET));

    assert_link_down_R3: assert property (@(posedge clk) disable iff (rst)
        (link_q && !link_up_i) |=>
            (!regs_q[IDX_STAT][LINK_BIT] && ((regs_q[IDX_PARTNER] & ~PARTNER_DN_KEEP) == '0)));

    assert_soft_reset_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.kind == WR_SOFT_RST) |=> (regs_q[IDX_CTRL] == INIT_CTRL && regs_q[IDX_ADV] == INIT_ADV));

    assert_ctrl_store_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.kind == WR_STORE && int'(cmd_i.idx) == IDX_CTRL) |=> (regs_q[IDX_CTRL] == $past(cmd_i.data)));

    assert_id_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.kind != WR_SOFT_RST) |=> ($stable(regs_q[IDX_ID_HI]) && $stable(regs_q[IDX_ID_LO])));

endmodule

// File: rtl/phy_mgmt_rdport.sv
module phy_mgmt_rdport
    import phy_mgmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en_i,
    input  logic                hit_i,
    input  logic [IDX_BITS-1:0] idx_i,
    input  word_t               regs_i [PHY_REGS],
    output word_t               rd_data_o
);

    word_t rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en_i) begin
            rd_q <= hit_i ? regs_i[idx_i] : '0;
        end
    end

    assign rd_data_o = rd_q;

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(rd_data_o));

    assert_rd_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !hit_i) |=> (rd_data_o == '0));

endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] idx_i,
    input  logic              wr_en_i,
    input  logic [PHY_DW-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic              link_up_i,
    output logic [PHY_DW-1:0] rd_data_o
);

    logic                hit;
    logic [IDX_BITS-1:0] idx;
    wr_cmd_t             cmd;
    word_t               regs [PHY_REGS];

    phy_mgmt_decode #(.ADDR_W(ADDR_W)) u_decode (
        .idx_i     (idx_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .hit_o     (hit),
        .idx_o     (idx),
        .cmd_o     (cmd)
    );

    phy_mgmt_store u_store (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd),
        .link_up_i (link_up_i),
        .regs_o    (regs)
    );

    phy_mgmt_rdport u_rdport (
        .clk       (clk),
        .rst       (rst),
        .rd_en_i   (rd_en_i),
        .hit_i     (hit),
        .idx_i     (idx),
        .regs_i    (regs),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: tb/phy_mgmt_regfile_tb.sv
module phy_mgmt_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  idx_i;
    logic        wr_en_i;
    logic [15:0] wr_data_i;
    logic        rd_en_i;
    logic        link_up_i;
    logic [15:0] rd_data_o;

    always #4 clk = ~clk;

    phy_mgmt_regfile #(.ADDR_W(5)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .idx_i     (idx_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .link_up_i (link_up_i),
        .rd_data_o (rd_data_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Behavioural reference model
    int unsigned mdl [16];
    int unsigned m_rd;
    bit          m_prev;

    function automatic void mdl_init();
        for (int i = 0; i < 16; i++) mdl[i] = 0;
        mdl[0] = 'h1000; mdl[1] = 'h7848; mdl[2] = 'h2000;
        mdl[3] = 'h5C90; mdl[4] = 'h01E1;
    endfunction

    function automatic void mdl_link(bit up);
        if (up) begin
            mdl[1] = mdl[1] | 'h4;
            mdl[5] = mdl[5] | 'h01E1;
        end else begin
            mdl[1] = mdl[1] & 'hFFFB;
            mdl[5] = mdl[5] & 'h01FF;
        end
    endfunction

    always @(posedge clk) begin : model
        bit reinit;
        reinit = rst;
        if (rst) begin
            m_rd = 0;
            mdl_init();
        end else begin
            if (rd_en_i) m_rd = (idx_i < 16) ? mdl[idx_i] : 0;
            if (wr_en_i && idx_i < 16) begin
                if (idx_i == 0) begin
                    if (wr_data_i[15]) begin
                        mdl_init();
                        reinit = 1'b1;
                    end else begin
                        mdl[0] = wr_data_i;
                    end
                end else if (idx_i > 3) begin
                    mdl[idx_i] = wr_data_i;
                end
            end
        end
        if (reinit || link_up_i != m_prev) mdl_link(link_up_i);
        m_prev = link_up_i;
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (rd_data_o !== m_rd[15:0]) begin
                errors++;
                $display("FAIL R8 model compare: actual %h expected %h", rd_data_o, m_rd[15:0]);
            end
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [15:0] data);
        idx_i = 5'(idx); wr_data_i = data; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd_chk(int idx, logic [15:0] exp, string tag);
        idx_i = 5'(idx); rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        chk(tag, rd_data_o, exp);
    endtask

    initial begin
        rst = 1'b1; idx_i = '0; wr_en_i = 1'b0; wr_data_i = '0;
        rd_en_i = 1'b0; link_up_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 rd_data after reset", rd_data_o, 16'h0000);
        rd_chk(0, 16'h1000, "R1 ctrl");
        rd_chk(1, 16'h7848, "R1 status link down");
        rd_chk(2, 16'h2000, "R1 id hi");
        rd_chk(3, 16'h5C90, "R1 id lo");
        rd_chk(4, 16'h01E1, "R1 adv");
        rd_chk(5, 16'h0000, "R1 partner link down");
        rd_chk(9, 16'h0000, "R1 general word");

        // R2: link rises with no access pending
        link_up_i = 1'b1;
        @(negedge clk);
        rd_chk(1, 16'h784C, "R2 status link bit");
        rd_chk(5, 16'h01E1, "R2 partner bits set");

        // R6 then R3: written partner value masked on link drop
        wr(5, 16'hFFFF);
        rd_chk(5, 16'hFFFF, "R6 partner write persists");
        link_up_i = 1'b0;
        @(negedge clk);
        rd_chk(5, 16'h01FF, "R3 partner masked");
        rd_chk(1, 16'h7848, "R3 status link bit clear");

        // R5
        wr(1, 16'h0000); wr(2, 16'hFFFF); wr(3, 16'h0000);
        rd_chk(1, 16'h7848, "R5 status write ignored");
        rd_chk(2, 16'h2000, "R5 id hi write ignored");
        rd_chk(3, 16'h5C90, "R5 id lo write ignored");

        // R4 / R6 stores
        wr(0, 16'h0100);
        rd_chk(0, 16'h0100, "R4 ctrl stored");
        wr(4, 16'hABCD);
        wr(15, 16'h1234);
        rd_chk(4, 16'hABCD, "R6 adv stored");
        rd_chk(15, 16'h1234, "R6 last index stored");

        // R7 out-of-range
        wr(16, 16'hBEEF);
        wr(31, 16'hCAFE);
        rd_chk(0, 16'h0100, "R7 index 16 alias not written");
        rd_chk(15, 16'h1234, "R7 index 31 alias not written");
        rd_chk(16, 16'h0000, "R7 out-of-range read");

        // R4 / R9 soft reset with link up
        link_up_i = 1'b1;
        @(negedge clk);
        wr(0, 16'h8000);
        rd_chk(0, 16'h1000, "R4 soft reset ctrl not stored");
        rd_chk(4, 16'h01E1, "R9 adv restored");
        rd_chk(15, 16'h0000, "R9 general cleared");
        rd_chk(1, 16'h784C, "R9 status link reapplied");
        rd_chk(5, 16'h01E1, "R9 partner link reapplied");

        // R8 hold and read-before-write
        rd_chk(2, 16'h2000, "R8 read before hold");
        repeat (3) @(negedge clk);
        chk("R8 held with no strobe", rd_data_o, 16'h2000);
        idx_i = 5'd6; wr_data_i = 16'h5555; wr_en_i = 1'b1; rd_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; rd_en_i = 1'b0;
        chk("R8 same-cycle write not visible", rd_data_o, 16'h0000);
        rd_chk(6, 16'h5555, "R8 write visible later");

        // R1 hardware reset with link up
        rst = 1'b1;
        @(negedge clk);
        chk("R1 rd_data cleared by reset", rd_data_o, 16'h0000);
        rst = 1'b0;
        rd_chk(1, 16'h784C, "R1 status link up after reset");
        rd_chk(5, 16'h01E1, "R1 partner link up after reset");
        rd_chk(6, 16'h0000, "R1 general cleared by reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule